// File: doc/BRIEF.md
# Two-Word Funnel Shifter

This unit joins a low data word and a high data word into one wider value and extracts a single data word from it by shifting left or right. The shift amount comes from a full-width register operand or from a short immediate that is zero-extended. A range mode chooses plain word-width shifting, or double-width shifting with a logical or an arithmetic fill of the high word.

An amount at or beyond the selected range is handled in one of two ways, picked per operation. It is either wrapped by keeping only its low bits, or it forces the result to zero. Zero and negative flags can be updated from the result, or left unchanged. Operands are taken when the input strobe is high. Result, flags and an output strobe are registered and appear one clock later. The unit is meant to sit in an integer execute stage next to the plain shifters.

Top module: `funnel_shift_unit`

## Requirements
- R1: With `shift_left`=1 and amount n below the word width, the result is (`word_hi` << n) OR (`word_lo` >> (32 − n)). A shift of 32 or more inside this expression gives zero.
- R2: With `shift_left`=0 and amount n below the word width, the result is (`word_lo` >> n) OR (`word_hi` << (32 − n)). Both shifts are logical.
- R3: An amount of zero returns `word_hi` unchanged for a left shift and `word_lo` unchanged for a right shift.
- R4: With `wrap_amt`=1 the amount is ANDed with 31 when `range_sel`=0, and with 63 when `range_sel` is 1 or 2.
- R5: With `wrap_amt`=0, an unsigned amount at or above the range limit forces the result to zero. The limit is 32 for `range_sel`=0 and 64 for `range_sel` 1 or 2.
- R6: In a double-width mode (`range_sel` 1 or 2), a left shift with amount n in 32..63 gives `word_lo` << (n − 32).
- R7: With `range_sel`=1, a right shift with amount n in 32..63 gives `word_hi` logically shifted right by (n − 32).
- R8: With `range_sel`=2, a right shift with amount n in 32..63 gives `word_hi` arithmetically shifted right by (n − 32).
- R9: With `use_imm`=1 the amount is the 6-bit `amt_imm`, zero-extended, and `amt_reg` is ignored. With `use_imm`=0 the amount is `amt_reg`.
- R10: When an operation is taken with `flag_en`=1, `flag_zero` is set to (result == 0) and `flag_neg` is set to result bit 31, both appearing with the result.
- R11: When an operation is taken with `flag_en`=0, or no operation is taken, both flags keep their values.
- R12: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `result` changes only in that cycle and holds otherwise.
- R13: A synchronous active-low reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Take an operation this cycle |
| word_lo | input | 32 | Low data word |
| word_hi | input | 32 | High data word |
| amt_reg | input | 32 | Register shift amount |
| amt_imm | input | 6 | Immediate shift amount |
| use_imm | input | 1 | 1: use the immediate amount |
| shift_left | input | 1 | 1: left, 0: right |
| range_sel | input | 2 | 0: word width, 1: double unsigned, 2: double signed (3 acts as 0) |
| wrap_amt | input | 1 | 1: wrap the amount, 0: clamp to zero |
| flag_en | input | 1 | Update flags from this operation |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Shifted word |
| flag_zero | output | 1 | Result was zero |
| flag_neg | output | 1 | Result bit 31 |

## Verification
The assertions check on every cycle the one-clock strobe timing, that the result and flags hold when they should, that the flags agree with the registered result, that an out-of-range clamped amount gives zero, and that a zero left shift passes the high word through. The bench's vector table must show the actual bit arithmetic: both funnel directions, wrapping to 31 and to 63, the double-width cases with logical and arithmetic fill, and the immediate source overriding the register operand. The reset clearing the outputs partway through a run is also shown only by a directed scenario.

// File: rtl/fsh_pkg.sv
// Shared definitions for the funnel shifter.
// Assumes range codes are decoded upstream into the 2-bit field below.
package fsh_pkg;
    typedef enum logic [1:0] {
        RANGE_WORD = 2'd0,
        RANGE_DU   = 2'd1,
        RANGE_DS   = 2'd2,
        RANGE_RSVD = 2'd3
    } range_e;
endpackage

// File: rtl/fsh_amount.sv
// Shift amount resolution: picks the source, applies wrap or detects clamp.
// Assumes 2*DATA_W fits in DATA_W bits (DATA_W >= 8).
module fsh_amount #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 6
) (
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              use_imm,
    input  logic [1:0]        range_sel,
    input  logic              wrap_amt,
    output logic [DATA_W-1:0] amt_eff,
    output logic              long_mode,
    output logic              signed_mode,
    output logic              clamp_zero
);
    import fsh_pkg::*;

    localparam logic [DATA_W-1:0] SHORT_LIM = DATA_W'(DATA_W);
    localparam logic [DATA_W-1:0] LONG_LIM  = DATA_W'(2 * DATA_W);

    logic [DATA_W-1:0] raw_amt;
    logic [DATA_W-1:0] limit;

    // Decode range mode and select the raw amount source.
    always_comb begin
        long_mode   = (range_sel == RANGE_DU) || (range_sel == RANGE_DS);
        signed_mode = (range_sel == RANGE_DS);
        raw_amt     = use_imm ? DATA_W'(amt_imm) : amt_reg;
        limit       = long_mode ? LONG_LIM : SHORT_LIM;
    end

    // Apply modulo wrap or flag an out-of-range clamp.
    always_comb begin
        if (wrap_amt) begin
            amt_eff    = raw_amt & (limit - 1'b1);
            clamp_zero = 1'b0;
        end else begin
            amt_eff    = raw_amt;
            clamp_zero = (raw_amt >= limit);
        end
    end
endmodule

// File: rtl/fsh_core.sv
// Combinational funnel datapath over a resolved amount.
// Assumes amt is already wrapped or flagged by clamp_zero.
module fsh_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_lo,
    input  logic [DATA_W-1:0] word_hi,
    input  logic [DATA_W-1:0] amt,
    input  logic              shift_left,
    input  logic              long_mode,
    input  logic              signed_mode,
    input  logic              clamp_zero,
    output logic [DATA_W-1:0] res
);
    localparam logic [DATA_W-1:0] WIDTH_V = DATA_W'(DATA_W);

    function automatic logic [DATA_W-1:0] lsl(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] n);
        return (n >= WIDTH_V) ? '0 : (x << n);
    endfunction

    function automatic logic [DATA_W-1:0] lsr(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] n);
        return (n >= WIDTH_V) ? '0 : (x >> n);
    endfunction

    function automatic logic [DATA_W-1:0] asr(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] n);
        return (n >= WIDTH_V) ? {DATA_W{x[DATA_W-1]}} : DATA_W'($signed(x) >>> n);
    endfunction

    logic [DATA_W-1:0] comp_amt;
    logic [DATA_W-1:0] upper_amt;
    logic [DATA_W-1:0] base_res;
    logic [DATA_W-1:0] wide_res;
    logic              beyond_word;

    // Complementary and upper-half shift counts.
    always_comb begin
        comp_amt    = WIDTH_V - amt;
        upper_amt   = amt - WIDTH_V;
        beyond_word = (amt >= WIDTH_V);
    end

    // Funnel within one word and the double-width beyond-word term.
    always_comb begin
        if (shift_left) begin
            base_res = lsl(word_hi, amt) | lsr(word_lo, comp_amt);
            wide_res = lsl(word_lo, upper_amt);
        end else begin
            base_res = lsr(word_lo, amt) | lsl(word_hi, comp_amt);
            wide_res = signed_mode ? asr(word_hi, upper_amt) : lsr(word_hi, upper_amt);
        end
    end

    // Final select: clamp, double-width beyond word, or funnel.
    always_comb begin
        if (clamp_zero)
            res = '0;
        else if (long_mode && beyond_word)
            res = wide_res;
        else
            res = base_res;
    end
endmodule

// File: rtl/funnel_shift_unit.sv
// Registered funnel shifter: takes operands on in_valid, result one clock later.
// Assumes the caller holds no hazard state; flags persist until overwritten.
module funnel_shift_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] word_lo,
    input  logic [DATA_W-1:0] word_hi,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              use_imm,
    input  logic              shift_left,
    input  logic [1:0]        range_sel,
    input  logic              wrap_amt,
    input  logic              flag_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_neg
);
    logic [DATA_W-1:0] amt_eff;
    logic              long_mode;
    logic              signed_mode;
    logic              clamp_zero;
    logic [DATA_W-1:0] next_res;

    fsh_amount #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_amount (
        .amt_reg     (amt_reg),
        .amt_imm     (amt_imm),
        .use_imm     (use_imm),
        .range_sel   (range_sel),
        .wrap_amt    (wrap_amt),
        .amt_eff     (amt_eff),
        .long_mode   (long_mode),
        .signed_mode (signed_mode),
        .clamp_zero  (clamp_zero)
    );

    fsh_core #(.DATA_W(DATA_W)) u_core (
        .word_lo     (word_lo),
        .word_hi     (word_hi),
        .amt         (amt_eff),
        .shift_left  (shift_left),
        .long_mode   (long_mode),
        .signed_mode (signed_mode),
        .clamp_zero  (clamp_zero),
        .res         (next_res)
    );

    // Output strobe and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end

    // Condition flags, written only on enabled operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_zero <= 1'b0;
            flag_neg  <= 1'b0;
        end else if (in_valid && flag_en) begin
            flag_zero <= (next_res == '0);
            flag_neg  <= next_res[DATA_W-1];
        end
    end
endmodule

// File: rtl/funnel_shift_unit_chk.sv
// Property checker for funnel_shift_unit, attached by bind.
module funnel_shift_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] word_hi,
    input logic [DATA_W-1:0] amt_reg,
    input logic [IMM_W-1:0]  amt_imm,
    input logic              use_imm,
    input logic              shift_left,
    input logic [1:0]        range_sel,
    input logic              wrap_amt,
    input logic              flag_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_zero,
    input logic              flag_neg
);
    logic [DATA_W-1:0] chk_amt;
    logic [DATA_W-1:0] chk_lim;

    always_comb begin
        chk_amt = use_imm ? DATA_W'(amt_imm) : amt_reg;
        chk_lim = (range_sel == 2'd1 || range_sel == 2'd2) ? DATA_W'(2 * DATA_W) : DATA_W'(DATA_W);
    end

    // R12
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R12
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && flag_en) |=> $stable({flag_zero, flag_neg}));
    // R10
    flag_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_en) |=> (flag_neg == result[DATA_W-1]));
    // R10
    flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_en) |=> (flag_zero == (result == '0)));
    // R5
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wrap_amt && chk_amt >= chk_lim) |=> (result == '0));
    // R3
    zero_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_left && chk_amt == '0) |=> (result == $past(word_hi)));
endmodule

bind funnel_shift_unit funnel_shift_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .word_hi    (word_hi),
    .amt_reg    (amt_reg),
    .amt_imm    (amt_imm),
    .use_imm    (use_imm),
    .shift_left (shift_left),
    .range_sel  (range_sel),
    .wrap_amt   (wrap_amt),
    .flag_en    (flag_en),
    .out_valid  (out_valid),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg)
);

// File: tb/funnel_shift_unit_tb.sv
module funnel_shift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] word_lo = '0;
    logic [31:0] word_hi = '0;
    logic [31:0] amt_reg = '0;
    logic [5:0]  amt_imm = '0;
    logic        use_imm = 1'b0;
    logic        shift_left = 1'b0;
    logic [1:0]  range_sel = '0;
    logic        wrap_amt = 1'b0;
    logic        flag_en = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_zero;
    logic        flag_neg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    funnel_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .word_lo(word_lo), .word_hi(word_hi), .amt_reg(amt_reg),
        .amt_imm(amt_imm), .use_imm(use_imm), .shift_left(shift_left),
        .range_sel(range_sel), .wrap_amt(wrap_amt), .flag_en(flag_en),
        .out_valid(out_valid), .result(result),
        .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    // Vector: {req[4], lo[32], hi[32], areg[32], use_imm, imm[6], left, range[2], wrap, expect[32]}
    localparam int NV = 18;
    localparam logic [142:0] VEC [0:NV-1] = '{
        {4'd1,  32'h89ABCDEF, 32'h01234567, 32'd8,        1'b0, 6'd0,  1'b1, 2'd0, 1'b0, 32'h23456789}, // R1
        {4'd2,  32'h89ABCDEF, 32'h01234567, 32'd8,        1'b0, 6'd0,  1'b0, 2'd0, 1'b0, 32'h6789ABCD}, // R2
        {4'd3,  32'h89ABCDEF, 32'h01234567, 32'd0,        1'b0, 6'd0,  1'b1, 2'd0, 1'b0, 32'h01234567}, // R3
        {4'd3,  32'h89ABCDEF, 32'h01234567, 32'd0,        1'b0, 6'd0,  1'b0, 2'd0, 1'b0, 32'h89ABCDEF}, // R3
        {4'd1,  32'h89ABCDEF, 32'h01234567, 32'd31,       1'b0, 6'd0,  1'b1, 2'd0, 1'b0, 32'hC4D5E6F7}, // R1
        {4'd4,  32'h89ABCDEF, 32'h01234567, 32'd40,       1'b0, 6'd0,  1'b1, 2'd0, 1'b1, 32'h23456789}, // R4
        {4'd4,  32'h89ABCDEF, 32'h01234567, 32'hFFFFFFE4, 1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 32'h789ABCDE}, // R4
        {4'd5,  32'h89ABCDEF, 32'h01234567, 32'd40,       1'b0, 6'd0,  1'b0, 2'd0, 1'b0, 32'h00000000}, // R5
        {4'd5,  32'h89ABCDEF, 32'h01234567, 32'd32,       1'b0, 6'd0,  1'b1, 2'd0, 1'b0, 32'h00000000}, // R5
        {4'd6,  32'h89ABCDEF, 32'h01234567, 32'd36,       1'b0, 6'd0,  1'b1, 2'd1, 1'b0, 32'h9ABCDEF0}, // R6
        {4'd7,  32'h89ABCDEF, 32'h87654321, 32'd40,       1'b0, 6'd0,  1'b0, 2'd1, 1'b0, 32'h00876543}, // R7
        {4'd8,  32'h89ABCDEF, 32'h87654321, 32'd40,       1'b0, 6'd0,  1'b0, 2'd2, 1'b0, 32'hFF876543}, // R8
        {4'd5,  32'h89ABCDEF, 32'h01234567, 32'd64,       1'b0, 6'd0,  1'b0, 2'd1, 1'b0, 32'h00000000}, // R5
        {4'd4,  32'h89ABCDEF, 32'h01234567, 32'd72,       1'b0, 6'd0,  1'b0, 2'd1, 1'b1, 32'h6789ABCD}, // R4
        {4'd9,  32'h89ABCDEF, 32'h01234567, 32'hFFFFFFFF, 1'b1, 6'd8,  1'b1, 2'd0, 1'b0, 32'h23456789}, // R9
        {4'd9,  32'h89ABCDEF, 32'h87654321, 32'hFFFFFFFF, 1'b1, 6'd63, 1'b0, 2'd2, 1'b0, 32'hFFFFFFFF}, // R9 R8
        {4'd6,  32'h89ABCDEF, 32'h01234567, 32'd0,        1'b1, 6'd32, 1'b1, 2'd1, 1'b0, 32'h89ABCDEF}, // R6
        {4'd2,  32'h89ABCDEF, 32'h87654321, 32'd8,        1'b0, 6'd0,  1'b0, 2'd2, 1'b0, 32'h2189ABCD}  // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; result is sampled one falling edge later.
    task automatic issue(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] ar,
                         input logic ui, input logic [5:0] im, input logic lf,
                         input logic [1:0] rs, input logic wr, input logic fe);
        @(negedge clk);
        word_lo = lo; word_hi = hi; amt_reg = ar; use_imm = ui; amt_imm = im;
        shift_left = lf; range_sel = rs; wrap_amt = wr; flag_en = fe; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 out_valid in reset", 32'(out_valid), 32'd0);
        check("R13 result in reset", result, 32'd0);
        check("R13 flags in reset", 32'({flag_zero, flag_neg}), 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R12: vector table
        for (int i = 0; i < NV; i++) begin
            logic [142:0] v;
            v = VEC[i];
            issue(v[138:107], v[106:75], v[74:43], v[42], v[41:36], v[35], v[34:33], v[32], 1'b1);
            check($sformatf("R%0d vector %0d result", v[142:139], i), result, v[31:0]);
            check($sformatf("R12 vector %0d out_valid", i), 32'(out_valid), 32'd1);
            check($sformatf("R10 vector %0d zero flag", i), 32'(flag_zero), 32'(v[31:0] == 32'd0));
            check($sformatf("R10 vector %0d neg flag", i), 32'(flag_neg), 32'(v[31]));
        end

        // R11: zero result with flags disabled leaves flags from 2189ABCD (z0 n0)
        issue(32'h89ABCDEF, 32'h01234567, 32'd32, 1'b0, 6'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        check("R11 result written", result, 32'd0);
        check("R11 flags held", 32'({flag_zero, flag_neg}), 32'd0);
        // R11: negative result with flags disabled
        issue(32'h89ABCDEF, 32'h87654321, 32'd63, 1'b0, 6'd0, 1'b0, 2'd2, 1'b0, 1'b0);
        check("R11 neg result written", result, 32'hFFFFFFFF);
        check("R11 flags held again", 32'({flag_zero, flag_neg}), 32'd0);

        // R10: enabled zero result sets zero flag
        issue(32'h89ABCDEF, 32'h01234567, 32'd64, 1'b0, 6'd0, 1'b1, 2'd2, 1'b0, 1'b1);
        check("R10 zero flag set", 32'({flag_zero, flag_neg}), 32'b10);

        // R12: idle cycles with changing inputs keep result and drop strobe
        @(negedge clk);
        word_hi = 32'hDEADBEEF; amt_reg = 32'd0; shift_left = 1'b1; flag_en = 1'b1;
        @(negedge clk);
        check("R12 strobe low when idle", 32'(out_valid), 32'd0);
        check("R12 result held when idle", result, 32'd0);
        check("R11 flags held when idle", 32'({flag_zero, flag_neg}), 32'b10);

        // R13: reset in mid-run clears everything
        issue(32'h89ABCDEF, 32'h87654321, 32'd40, 1'b0, 6'd0, 1'b0, 2'd2, 1'b0, 1'b1);
        check("R8 before reset", result, 32'hFF876543);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R13 out_valid cleared", 32'(out_valid), 32'd0);
        check("R13 result cleared", result, 32'd0);
        check("R13 flags cleared", 32'({flag_zero, flag_neg}), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule